// File: doc/BRIEF.md
# Per-CPU Interrupt Level Controller

This block keeps the local interrupt pending state of one processor and turns it into fifteen active-high interrupt-level lines, for levels 1 to 15. Four sources feed the lines. The first is a vector of hard levels that the system-side controller has already routed to this CPU. The second is a per-CPU timer request. The third is a level-15 request broadcast to every CPU. The fourth is a set of fifteen software interrupt bits held in the upper part of the pending word. Level 0 has no line.

Software reaches the block through a 32-bit, word-only register window of four word slots, selected by the address shifted right by two. Slot 0 reads the pending word. Slot 1 clears pending bits and slot 2 sets software bits. Slot 3 does nothing. A global master-off flag silences the timer and level-15 contributions. It does not silence the software bits or the routed hard levels. The output lines are registered, so the processor sees a clean level vector that moves only when the computed vector moves.

Top module: `ilc_cpu_level_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the pending word reads 0 and every output level line is low.
- R2: A write to slot 2 (byte 0x8) ORs the written data, masked to bits 31..17, into the pending word. All other written bits, including bit 16, are ignored.
- R3: A write to slot 1 (byte 0x4) clears every pending bit that is set in the data within bits 31..17 and bit 15. It leaves bit 14 and the hard-level bits untouched.
- R4: A read of slot 0 (byte 0x0) returns the pending word. Bits 31..17 hold the software bits, bit 15 the level-15 request and bit 14 the timer request, and bits n (1..15) are ORed with routed hard level n. Slots 1, 2 and 3 read as 0, and a write to slot 3 changes nothing.
- R5: Software pending bit n+16 drives output level n, for n from 1 to 15, whatever the master-off flag.
- R6: Pending bit 14 follows the timer request one clock later: it is set while the request is high and clear once the request is low.
- R7: A rising level-15 request sets pending bit 15 and a falling one clears it. Software may clear the bit while the request stays high, and the bit then stays clear until the next rising edge.
- R8: Pending bits 14 and 15 drive output levels 14 and 15 only while master-off is low. Master-off does not change the pending word.
- R9: Routed hard levels are not latched. They show in the pending read in the same cycle and reach the output one clock later, and they vanish once the routed vector drops them.
- R10: Each output line is registered from the computed level vector. A line whose computed value does not change keeps its value, with no glitch when other lines change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register window |
| bus_wr | input | 1 | Write strobe for one 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed slot, combinational |
| routed_lvl | input | 15 | Hard levels routed to this CPU; bit n is level n (1..15) |
| master_off | input | 1 | Global master-off flag, masks timer and level-15 contributions |
| tmr_req | input | 1 | Per-CPU timer request |
| lvl15_req | input | 1 | Broadcast level-15 request |
| cpu_lvl | output | 15 | Registered interrupt-level lines; bit n is level n (1..15) |

## Verification
The in-line assertions check the following on every cycle: the masking on set and clear writes, the one-cycle timer tracking, the level-15 edge set and clear, master-off suppression of levels 14 and 15, reset clearing, and the rule that an output line holds while its computed value is steady. Some behaviours need whole scenarios and only the bench's directed tests show them. These are the full composition of the pending read, slot decoding with the silent slot 3, a software clear that outlives a still-high level-15 request, and hard levels vanishing without a write. The bench also shows master-off leaving the pending word intact, and the register-by-register latency to each output line.

// File: rtl/ilc_pkg.sv
// Package: shared constants and slot encoding for the per-CPU interrupt
// level controller. Assumes a 32-bit word and fifteen levels (1..15).
package ilc_pkg;
    localparam int WORD_W     = 32;
    localparam int NUM_LVL    = 15;
    localparam int SOFT_SHIFT = 16;
    localparam int TMR_BIT    = 14;
    localparam int L15_BIT    = 15;

    localparam logic [WORD_W-1:0] SET_MASK = 32'hFFFE_0000;
    localparam logic [WORD_W-1:0] CLR_MASK = 32'hFFFE_8000;

    typedef enum logic [1:0] {
        SLOT_PEND = 2'd0,
        SLOT_CLR  = 2'd1,
        SLOT_SET  = 2'd2,
        SLOT_NONE = 2'd3
    } slot_e;
endpackage

// File: rtl/ilc_pend_regs.sv
// Module: pending-word storage. Holds the software bits, the timer copy and
// the edge-tracked level-15 bit, applies set/clear writes, and builds the
// read view, with routed hard levels ORed in combinationally.
// Assumes one write per cycle and a single decoded slot.
module ilc_pend_regs
    import ilc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  slot_e                slot,
    input  logic [WORD_W-1:0]    wdata,
    input  logic                 tmr_req,
    input  logic                 lvl15_req,
    input  logic [NUM_LVL:1]     routed_lvl,
    output logic [NUM_LVL:1]     soft_lv,
    output logic                 tmr_q,
    output logic                 l15_q,
    output logic [WORD_W-1:0]    pend_view
);
    localparam int SOFT_LO = SOFT_SHIFT + 1;

    logic             set_hit;
    logic             clr_hit;
    logic [WORD_W-1:0] set_bits;
    logic [WORD_W-1:0] clr_bits;
    logic             l15_prev;
    logic             unused_bits;

    assign set_hit  = wr && (slot == SLOT_SET);
    assign clr_hit  = wr && (slot == SLOT_CLR);
    assign set_bits = wdata & SET_MASK;
    assign clr_bits = wdata & CLR_MASK;
    assign unused_bits = ^{set_bits[SOFT_SHIFT:0], clr_bits[SOFT_SHIFT:0]};

    // Software bits: set and clear through their own slots.
    always_ff @(posedge clk) begin
        if (!rst_n)
            soft_lv <= '0;
        else if (set_hit)
            soft_lv <= soft_lv | set_bits[WORD_W-1:SOFT_LO];
        else if (clr_hit)
            soft_lv <= soft_lv & ~clr_bits[WORD_W-1:SOFT_LO];
    end

    // Timer bit: a registered copy of the request level.
    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= 1'b0;
        else        tmr_q <= tmr_req;
    end

    // Level-15 bit: set on rising request, cleared on falling or by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l15_prev <= 1'b0;
            l15_q    <= 1'b0;
        end else begin
            l15_prev <= lvl15_req;
            if (lvl15_req && !l15_prev)
                l15_q <= 1'b1;
            else if (!lvl15_req && l15_prev)
                l15_q <= 1'b0;
            else if (clr_hit && clr_bits[L15_BIT])
                l15_q <= 1'b0;
        end
    end

    // Read view: stored bits plus live hard levels.
    always_comb begin
        pend_view = '0;
        pend_view[WORD_W-1:SOFT_LO] = soft_lv;
        pend_view[L15_BIT] = l15_q;
        pend_view[TMR_BIT] = tmr_q;
        pend_view[NUM_LVL:1] = pend_view[NUM_LVL:1] | routed_lvl;
    end

    assert_set_soft_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_hit |=> ((soft_lv & $past(wdata[WORD_W-1:SOFT_LO])) == $past(wdata[WORD_W-1:SOFT_LO])));

    assert_clear_soft_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> ((soft_lv & $past(wdata[WORD_W-1:SOFT_LO])) == '0));

    assert_timer_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (tmr_q == $past(tmr_req)));

    assert_l15_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl15_req && !l15_prev) |=> l15_q);

    assert_l15_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl15_req && l15_prev) |=> !l15_q);
endmodule

// File: rtl/ilc_lvl_merge.sv
// Module: merges routed hard levels, software levels and the master-gated
// timer and level-15 bits into the level vector, one register per line.
// Assumes all inputs are synchronous to clk.
module ilc_lvl_merge
    import ilc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_LVL:1] routed_lvl,
    input  logic [NUM_LVL:1] soft_lv,
    input  logic             tmr_q,
    input  logic             l15_q,
    input  logic             master_off,
    output logic [NUM_LVL:1] cpu_lvl
);
    logic [NUM_LVL:1] gated_lv;
    logic [NUM_LVL:1] lvl_next;

    // Timer and level-15 bits pass only while master-off is low.
    always_comb begin
        gated_lv = '0;
        if (!master_off) begin
            gated_lv[L15_BIT] = l15_q;
            gated_lv[TMR_BIT] = tmr_q;
        end
    end

    assign lvl_next = routed_lvl | soft_lv | gated_lv;

    for (genvar n = 1; n <= NUM_LVL; n++) begin : g_line
        // One output flop per level, loaded only when its value changes.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cpu_lvl[n] <= 1'b0;
            else if (cpu_lvl[n] != lvl_next[n])
                cpu_lvl[n] <= lvl_next[n];
        end
    end

    assert_master_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (master_off && !routed_lvl[TMR_BIT] && !soft_lv[TMR_BIT] &&
         !routed_lvl[L15_BIT] && !soft_lv[L15_BIT]) |=> (cpu_lvl[L15_BIT:TMR_BIT] == 2'b00));

    assert_soft_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((cpu_lvl & $past(soft_lv)) == $past(soft_lv)));

    assert_no_glitch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && lvl_next == $past(lvl_next)) |=> $stable(cpu_lvl));

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (cpu_lvl == '0));
endmodule

// File: rtl/ilc_cpu_level_ctrl.sv
// Module: top of the per-CPU interrupt level controller. Decodes the
// word-indexed register window and connects storage to the merge stage.
// Assumes word-only accesses; the two low address bits are ignored.
module ilc_cpu_level_ctrl
    import ilc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [15:1]       routed_lvl,
    input  logic              master_off,
    input  logic              tmr_req,
    input  logic              lvl15_req,
    output logic [15:1]       cpu_lvl
);
    localparam int SLOT_LO = 2;

    slot_e             slot;
    logic [WORD_W-1:0] pend_view;
    logic [NUM_LVL:1]  soft_lv;
    logic              tmr_q;
    logic              l15_q;
    logic              unused_addr;

    assign slot        = slot_e'(bus_addr[SLOT_LO+1:SLOT_LO]);
    assign unused_addr = ^bus_addr[SLOT_LO-1:0];

    // Read mux: only the pending slot returns data.
    always_comb begin
        bus_rdata = (slot == SLOT_PEND) ? pend_view : '0;
    end

    ilc_pend_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (bus_wr),
        .slot       (slot),
        .wdata      (bus_wdata),
        .tmr_req    (tmr_req),
        .lvl15_req  (lvl15_req),
        .routed_lvl (routed_lvl),
        .soft_lv    (soft_lv),
        .tmr_q      (tmr_q),
        .l15_q      (l15_q),
        .pend_view  (pend_view)
    );

    ilc_lvl_merge u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .routed_lvl (routed_lvl),
        .soft_lv    (soft_lv),
        .tmr_q      (tmr_q),
        .l15_q      (l15_q),
        .master_off (master_off),
        .cpu_lvl    (cpu_lvl)
    );
endmodule

// File: tb/ilc_cpu_level_ctrl_tb.sv
module ilc_cpu_level_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:1] routed_lvl = '0;
    logic        master_off = 1'b0;
    logic        tmr_req = 1'b0;
    logic        lvl15_req = 1'b0;
    logic [15:1] cpu_lvl;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    ilc_cpu_level_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .routed_lvl(routed_lvl),
        .master_off(master_off), .tmr_req(tmr_req), .lvl15_req(lvl15_req),
        .cpu_lvl(cpu_lvl)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lv();
        return {16'h0, cpu_lvl, 1'b0};
    endfunction

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 4'h0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'h0, d);
        chk("R1 pending after reset", d, 32'h0);
        chk("R1 levels after reset", lv(), 32'h0);
    endtask

    task automatic t_set_clear();
        logic [31:0] d;
        wr(4'h8, 32'hFFFF_FFFF);
        rd(4'h0, d);
        chk("R2 set masked to soft bits", d, 32'hFFFE_0000);
        step();
        chk("R5 all soft levels", lv(), 32'h0000_FFFE);
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h0, d);
        chk("R3 clear all soft", d, 32'h0);
        step();
        chk("R3 levels after clear", lv(), 32'h0);
        wr(4'h8, 32'h0010_0000);
        step();
        rd(4'h0, d);
        chk("R2 single soft bit 20", d, 32'h0010_0000);
        chk("R5 soft bit 20 drives level 4", lv(), 32'h0000_0010);
        wr(4'h4, 32'h0010_0000);
        step();
    endtask

    task automatic t_slots();
        logic [31:0] d;
        wr(4'h8, 32'h8000_0000);
        rd(4'h4, d); chk("R4 slot 1 reads zero", d, 32'h0);
        rd(4'h8, d); chk("R4 slot 2 reads zero", d, 32'h0);
        rd(4'hC, d); chk("R4 slot 3 reads zero", d, 32'h0);
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'h0, d); chk("R4 slot 3 write ignored", d, 32'h8000_0000);
        wr(4'h4, 32'h8000_0000);
        step();
    endtask

    task automatic t_timer();
        logic [31:0] d;
        tmr_req = 1'b1;
        step();
        rd(4'h0, d);
        chk("R6 timer bit set", d, 32'h0000_4000);
        step();
        chk("R6 timer reaches level 14", lv(), 32'h0000_4000);
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h0, d);
        chk("R3 clear leaves timer bit", d, 32'h0000_4000);
        master_off = 1'b1;
        step();
        chk("R8 master-off masks level 14", lv(), 32'h0);
        rd(4'h0, d);
        chk("R8 pending kept under master-off", d, 32'h0000_4000);
        master_off = 1'b0;
        tmr_req = 1'b0;
        step();
        rd(4'h0, d);
        chk("R6 timer bit clears", d, 32'h0);
        step();
    endtask

    task automatic t_l15();
        logic [31:0] d;
        lvl15_req = 1'b1;
        step();
        rd(4'h0, d);
        chk("R7 rise sets bit 15", d, 32'h0000_8000);
        step();
        chk("R7 level 15 out", lv(), 32'h0000_8000);
        wr(4'h4, 32'h0000_8000);
        step();
        rd(4'h0, d);
        chk("R7 software clear while held", d, 32'h0);
        lvl15_req = 1'b0; step();
        lvl15_req = 1'b1; step();
        rd(4'h0, d);
        chk("R7 second rise sets again", d, 32'h0000_8000);
        lvl15_req = 1'b0; step();
        rd(4'h0, d);
        chk("R7 fall clears", d, 32'h0);
        step();
    endtask

    task automatic t_hard();
        logic [31:0] d;
        master_off = 1'b1;
        routed_lvl = 15'h1002;
        rd(4'h0, d);
        chk("R9 hard levels read same cycle", d, 32'h0000_2004);
        step();
        chk("R9 hard levels pass master-off", lv(), 32'h0000_2004);
        routed_lvl = '0;
        rd(4'h0, d);
        chk("R9 hard levels vanish", d, 32'h0);
        step();
        chk("R9 output drops", lv(), 32'h0);
        master_off = 1'b0;
    endtask

    task automatic t_glitch();
        wr(4'h8, 32'h0010_0000);
        step();
        chk("R10 level 4 up", lv(), 32'h0000_0010);
        wr(4'h8, 32'h0020_0000);
        chk("R10 level 4 held across change", lv() & 32'h10, 32'h10);
        step();
        chk("R10 levels 4 and 5", lv(), 32'h0000_0030);
        wr(4'h4, 32'h0020_0000);
        chk("R10 level 4 held on clear", lv() & 32'h10, 32'h10);
        step();
        chk("R10 level 4 only", lv(), 32'h0000_0010);
    endtask

    initial begin : watchdog
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_set_clear();
        t_slots();
        t_timer();
        t_l15();
        t_hard();
        t_glitch();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule